// File: doc/BRIEF.md
# Byte-Order-Aware Load/Store Lane Steering

This block sits between a load/store pipeline and a 64-bit memory data bus. Each request carries a byte address, an access size (byte, halfword, word or doubleword), a read/write flag, store data and a byte-order select. One clock later the block presents a bus access. The access carries active-low byte enables for the eight byte lanes, the doubleword-aligned address, and the store data moved onto the lanes that the access covers.

For loads, the memory answers on the read-data bus during the cycle in which the access is presented. On the next edge, the block picks the addressed bytes off their lanes, puts them into the low end of a result register and zero-fills the rest. Byte-order select low means little-endian order: the least significant byte of a value sits on the lowest lane of its group. Byte-order select high reverses the byte order within the group. The lanes a given access enables are the same in both orders.

An access whose address is not a multiple of its size is never split. Instead it raises a one-cycle data-access trap. No bus access is made, and the result register keeps its old value.

Top module: `lane_steer`

## Requirements
- R1: While rst_n is low and after its release, bus_valid, trap and ld_valid are 0, bus_be_n is 8'hFF, bus_wdata is 0 and ld_data is 0.
- R2: A request accepted with req_valid high at a clock edge appears on the bus outputs after that same edge. In a cycle that follows an edge without req_valid, bus_valid is 0 and bus_be_n is 8'hFF.
- R3: req_size encodes 0=byte, 1=halfword, 2=word, 3=doubleword (n = 1, 2, 4, 8 bytes). The lane offset is req_addr[2:0]. Bits offset to offset+n-1 of bus_be_n are 0 and all other bits are 1, in both byte orders.
- R4: For a little-endian store (big_endian=0), byte i of req_wdata (bits 8i+7:8i) appears on lane offset+i (bus_wdata bits 8(offset+i)+7 : 8(offset+i)).
- R5: For a big-endian store (big_endian=1), byte i of req_wdata appears on lane offset+n-1-i. A doubleword is fully byte-reversed.
- R6: Every bus_wdata lane whose enable is 1 (inactive) reads 0. For a load, all of bus_wdata is 0.
- R7: For a little-endian load, one edge after bus_valid, ld_valid pulses high for one cycle. In that cycle, byte i of ld_data equals lane offset+i of bus_rdata for i < n, and bytes i >= n are 0.
- R8: For a big-endian load, byte i of ld_data equals lane offset+n-1-i of bus_rdata for i < n, and the upper bytes are 0.
- R9: A request whose req_addr[2:0] is not a multiple of n raises trap for exactly the following cycle. In that cycle bus_valid is 0 and bus_be_n is 8'hFF.
- R10: Trapped requests, stores and idle cycles leave ld_data unchanged and ld_valid at 0.
- R11: bus_addr is req_addr with its three low bits cleared, and it is presented together with bus_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 64 | Store value, right-aligned |
| big_endian | input | 1 | 1 selects reversed byte order |
| bus_valid | output | 1 | Bus access presented |
| bus_write | output | 1 | Bus access is a store |
| bus_addr | output | 32 | Doubleword-aligned address |
| bus_be_n | output | 8 | Active-low byte enables, one per lane |
| bus_wdata | output | 64 | Store data on its lanes |
| bus_rdata | input | 64 | Load data from memory, valid while bus_valid |
| trap | output | 1 | Misaligned-access trap |
| ld_valid | output | 1 | ld_data updated this cycle |
| ld_data | output | 64 | Zero-extended load result |

## Verification
The bench targets accesses at the highest legal offset of each size, such as a byte at offset 7, a halfword at 6 and a word at 4. A design that got these wrong would enable lanes past lane 7 or wrap onto lane 0. Each size is also sent at every misaligned offset. A design that mishandled these would still pulse enables or overwrite the result. Big-endian doublewords and words are run against recognisable byte patterns, so that reversing the wrong span or reversing in little-endian mode shows as swapped lanes. Random loads stress the zero extension, which an incorrect design would break by leaking neighbouring lanes into the upper result bytes.

// File: rtl/lsteer_pkg.sv
package lsteer_pkg;
  localparam int unsigned BUS_W  = 64;
  localparam int unsigned LANES  = BUS_W / 8;
  localparam int unsigned OFS_W  = $clog2(LANES);
  localparam int unsigned SIZE_BITS = 2;

  typedef enum logic [SIZE_BITS-1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsteer_mask.sv
module lsteer_mask
  import lsteer_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  localparam int unsigned OW = $clog2(N_LANES)
) (
  input  logic [OW-1:0]        ofs,
  input  acc_size_e            size,
  output logic [N_LANES-1:0]   en,
  output logic                 misalign
);
  logic [OW:0]   nbytes;
  logic [OW-1:0] low_mask;

  always_comb begin
    int lo;
    int hi;
    nbytes   = (OW+1)'(1) << size;
    low_mask = OW'(nbytes - (OW+1)'(1));
    misalign = |(ofs & low_mask);
    lo = int'(ofs);
    hi = lo + int'(nbytes);
    for (int i = 0; i < int'(N_LANES); i++) begin
      en[i] = (i >= lo) && (i < hi);
    end
  end
endmodule

// File: rtl/lsteer_store.sv
module lsteer_store
  import lsteer_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  localparam int unsigned OW = $clog2(N_LANES),
  localparam int unsigned DW = N_LANES * 8
) (
  input  logic [DW-1:0]      wdata,
  input  logic [OW-1:0]      ofs,
  input  acc_size_e          size,
  input  logic               big,
  input  logic               write,
  input  logic [N_LANES-1:0] en,
  output logic [DW-1:0]      lanes
);
  logic [7:0] src_byte [N_LANES];

  for (genvar g = 0; g < int'(N_LANES); g++) begin : g_unpack
    assign src_byte[g] = wdata[g*8 +: 8];
  end

  always_comb begin
    int nb;
    int rel;
    int src;
    nb = 1 << size;
    lanes = '0;
    for (int i = 0; i < int'(N_LANES); i++) begin
      rel = i - int'(ofs);
      src = big ? (nb - 1 - rel) : rel;
      if (write && en[i]) begin
        lanes[i*8 +: 8] = src_byte[OW'(src)];
      end
    end
  end
endmodule

// File: rtl/lsteer_load.sv
module lsteer_load
  import lsteer_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  localparam int unsigned OW = $clog2(N_LANES),
  localparam int unsigned DW = N_LANES * 8
) (
  input  logic [DW-1:0] rdata,
  input  logic [OW-1:0] ofs,
  input  acc_size_e     size,
  input  logic          big,
  output logic [DW-1:0] result
);
  logic [7:0] lane_byte [N_LANES];

  for (genvar g = 0; g < int'(N_LANES); g++) begin : g_unpack
    assign lane_byte[g] = rdata[g*8 +: 8];
  end

  always_comb begin
    int nb;
    int lane;
    nb = 1 << size;
    result = '0;
    for (int j = 0; j < int'(N_LANES); j++) begin
      lane = big ? (int'(ofs) + nb - 1 - j) : (int'(ofs) + j);
      if (j < nb) begin
        result[j*8 +: 8] = lane_byte[OW'(lane)];
      end
    end
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lsteer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = BUS_W,
  localparam int unsigned NL = DATA_W / 8,
  localparam int unsigned OW = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              big_endian,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [NL-1:0]     bus_be_n,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              trap,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  acc_size_e         req_sz;
  logic [OW-1:0]     req_ofs;
  logic [NL-1:0]     lane_en;
  logic              mis;
  logic [DATA_W-1:0] steered;
  logic [DATA_W-1:0] picked;

  // registered state
  logic              bv_q, bw_q, trap_q, lv_q, big_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NL-1:0]     be_n_q;
  logic [DATA_W-1:0] wd_q, ld_q;
  logic [OW-1:0]     ofs_q;
  acc_size_e         sz_q;

  // next state
  logic              bv_d, trap_d, lv_d, acc_en, ld_en;
  logic [NL-1:0]     be_n_d;
  logic [DATA_W-1:0] wd_d;

  assign req_sz  = acc_size_e'(req_size);
  assign req_ofs = req_addr[OW-1:0];

  lsteer_mask #(.N_LANES(NL)) i_mask (
    .ofs(req_ofs), .size(req_sz), .en(lane_en), .misalign(mis)
  );

  lsteer_store #(.N_LANES(NL)) i_store (
    .wdata(req_wdata), .ofs(req_ofs), .size(req_sz), .big(big_endian),
    .write(req_write), .en(lane_en), .lanes(steered)
  );

  lsteer_load #(.N_LANES(NL)) i_load (
    .rdata(bus_rdata), .ofs(ofs_q), .size(sz_q), .big(big_q), .result(picked)
  );

  always_comb begin
    acc_en = req_valid && !mis;
    bv_d   = acc_en;
    trap_d = req_valid && mis;
    be_n_d = acc_en ? ~lane_en : '1;
    wd_d   = acc_en ? steered : '0;
    ld_en  = bv_q && !bw_q;
    lv_d   = ld_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bv_q   <= 1'b0;
      bw_q   <= 1'b0;
      trap_q <= 1'b0;
      lv_q   <= 1'b0;
      be_n_q <= '1;
      wd_q   <= '0;
      ld_q   <= '0;
      addr_q <= '0;
      ofs_q  <= '0;
      sz_q   <= ACC_BYTE;
      big_q  <= 1'b0;
    end else begin
      bv_q   <= bv_d;
      trap_q <= trap_d;
      lv_q   <= lv_d;
      be_n_q <= be_n_d;
      wd_q   <= wd_d;
      if (acc_en) begin
        bw_q   <= req_write;
        addr_q <= {req_addr[ADDR_W-1:OW], {OW{1'b0}}};
        ofs_q  <= req_ofs;
        sz_q   <= req_sz;
        big_q  <= big_endian;
      end
      if (ld_en) begin
        ld_q <= picked;
      end
    end
  end

  assign bus_valid = bv_q;
  assign bus_write = bw_q;
  assign bus_addr  = addr_q;
  assign bus_be_n  = be_n_q;
  assign bus_wdata = wd_q;
  assign trap      = trap_q;
  assign ld_valid  = lv_q;
  assign ld_data   = ld_q;

  // R9
  trap_blocks_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (!bv_q && be_n_q == '1));

  // R2
  idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bv_q |-> be_n_q == '1);

  // R2
  active_has_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> be_n_q != '1);

  // R10
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bv_q && !bw_q) |=> $stable(ld_q));

  // R7
  ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lv_q |=> !lv_q || $past(bv_q && !bw_q));

  // R11
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> addr_q[OW-1:0] == '0);

  for (genvar g = 0; g < int'(NL); g++) begin : g_lane_chk
    // R6
    quiet_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (be_n_q[g] || !bw_q) |-> wd_q[g*8 +: 8] == 8'h00);
  end
endmodule

// File: tb/test_lane_steer.sv
module test_lane_steer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, big_endian;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata, bus_rdata;
  logic        bus_valid, bus_write, trap, ld_valid;
  logic [31:0] bus_addr;
  logic [7:0]  bus_be_n;
  logic [63:0] bus_wdata, ld_data;

  int errors = 0;
  int checks = 0;
  logic [63:0] ld_model = '0;

  always #10 clk = ~clk;

  lane_steer i_lane_steer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .big_endian(big_endian), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .trap(trap), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic is_mis(input logic [2:0] ofs, input logic [1:0] sz);
    return (int'(ofs) % (1 << sz)) != 0;
  endfunction

  function automatic logic [7:0] exp_be(input logic [2:0] ofs, input logic [1:0] sz);
    logic [7:0] r = 8'hFF;
    for (int i = 0; i < (1 << sz); i++) r[int'(ofs) + i] = 1'b0;
    return r;
  endfunction

  function automatic logic [63:0] exp_wd(input logic [2:0] ofs, input logic [1:0] sz,
                                         input logic [63:0] v, input logic be);
    logic [63:0] r = '0;
    int n = 1 << sz;
    for (int i = 0; i < n; i++) begin
      if (be) r[(int'(ofs) + n - 1 - i)*8 +: 8] = v[i*8 +: 8];
      else    r[(int'(ofs) + i)*8 +: 8]         = v[i*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_ld(input logic [2:0] ofs, input logic [1:0] sz,
                                         input logic [63:0] bus, input logic be);
    logic [63:0] r = '0;
    int n = 1 << sz;
    for (int i = 0; i < n; i++) begin
      if (be) r[i*8 +: 8] = bus[(int'(ofs) + n - 1 - i)*8 +: 8];
      else    r[i*8 +: 8] = bus[(int'(ofs) + i)*8 +: 8];
    end
    return r;
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [63:0] wd, input logic be, input logic [63:0] rd);
    logic mis = is_mis(a[2:0], sz);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; big_endian = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 trap", {63'd0, trap}, {63'd0, mis});
    chk("R2 bus_valid", {63'd0, bus_valid}, {63'd0, !mis});
    if (mis) begin
      chk("R9 be_n blocked", {56'd0, bus_be_n}, 64'hFF);
    end else begin
      chk("R3 be_n", {56'd0, bus_be_n}, {56'd0, exp_be(a[2:0], sz)});
      chk("R11 bus_addr", {32'd0, bus_addr}, {32'd0, a[31:3], 3'b000});
      chk("R2 bus_write", {63'd0, bus_write}, {63'd0, wr});
      if (wr) chk(be ? "R5 R6 store lanes" : "R4 R6 store lanes", bus_wdata,
                  exp_wd(a[2:0], sz, wd, be));
      else    chk("R6 load wdata zero", bus_wdata, 64'd0);
    end
    bus_rdata = rd;
    if (!mis && !wr) ld_model = exp_ld(a[2:0], sz, rd, be);
    @(negedge clk);
    chk("R2 idle be_n", {56'd0, bus_be_n}, 64'hFF);
    chk("R7 R10 ld_valid", {63'd0, ld_valid}, {63'd0, !mis && !wr});
    chk(be ? "R8 R10 ld_data" : "R7 R10 ld_data", ld_data, ld_model);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_wdata = '0; big_endian = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset be_n", {56'd0, bus_be_n}, 64'hFF);
    chk("R1 reset valid/trap/ld", {61'd0, bus_valid, trap, ld_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release ld_data", ld_data, 64'd0);
    chk("R1 after release wdata", bus_wdata, 64'd0);

    // directed: every byte offset, both orders
    for (int k = 0; k < 8; k++) begin
      access(32'h100 + k, 2'd0, 1'b1, 64'h5A, k[0], '0);
      access(32'h200 + k, 2'd0, 1'b0, '0, k[1], 64'h8877665544332211);
    end
    // top legal offsets
    access(32'h306, 2'd1, 1'b1, 64'hBEEF, 1'b1, '0);
    access(32'h304, 2'd2, 1'b1, 64'hA1B2C3D4, 1'b1, '0);
    access(32'h304, 2'd2, 1'b0, '0, 1'b1, 64'h0807060504030201);
    access(32'h400, 2'd3, 1'b1, 64'h0102030405060708, 1'b1, '0);
    access(32'h400, 2'd3, 1'b0, '0, 1'b1, 64'hF0E0D0C0B0A09080);
    access(32'h400, 2'd3, 1'b0, '0, 1'b0, 64'h1122334455667788);
    // misaligned at every offset for each size
    for (int s = 1; s < 4; s++) begin
      for (int k = 0; k < 8; k++) begin
        access(32'h500 + k, 2'(s), k[2], 64'hFFFF_FFFF_FFFF_FFFF, k[0], 64'hDEAD_BEEF_0BAD_F00D);
      end
    end

    seed = $urandom(32'd2024);
    for (int t = 0; t < 600; t++) begin
      access($urandom, 2'($urandom), 1'($urandom), {$urandom, $urandom},
             1'($urandom), {$urandom, $urandom});
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule